// File: doc/BRIEF.md
# Mode-configurable SPI shift master

This block drives a serial peripheral bus as its master and moves an arbitrary number of bits per transfer, full duplex: every bit sent on MOSI is matched by one bit captured from MISO. The clock polarity and phase are chosen per transfer, and so is the half-period of SCK, given as a count of system clocks. Outgoing bytes arrive on a valid/ready stream and are pulled one at a time, one byte for each started group of eight bits. Captured bits are packed into bytes and returned on a one-cycle-pulse output stream.

A transfer starts with a single-cycle `start` while the block is idle. Two flags, sampled with `start`, decide whether chip select is asserted when the transfer begins and whether it is released when the transfer ends. One select window can therefore cover several transfers, for example a command transfer followed by a data transfer. If the bit count is not a multiple of eight, the last received byte holds its bits in its upper positions with zeros below. A zero bit count finishes at once with no clock edges. It still applies the chip-select flags.

Top module: `spi_shift_master`

## Requirements
- R1: While the block is idle, `sck` follows `cpol` with one clock of latency, so it rests at the idle level (0 when `cpol`=0, 1 when `cpol`=1).
- R2: `cs_n` (active low) goes low in the cycle after an accepted `start` only when `cs_begin` was 1 with it. Otherwise it keeps its level.
- R3: `cs_n` goes high in the cycle after `done` only when `cs_end` was 1 at the accepted `start`. Otherwise it stays low.
- R4: MOSI carries the bits MSB first. Bit k of a transfer is bit 7-(k mod 8) of the (k div 8)-th byte taken from the transmit stream. Its value is present when SCK moves from idle to active. `tx_ready` is raised once for each started group of 8 bits.
- R5: SCK stays active for exactly `half_div`+1 clocks per bit. With `cpha`=0 SCK turns active 2 busy cycles after `busy` rises, in the same cycle as the bit's MOSI value. With `cpha`=1 it turns active `half_div`+1 cycles later than that.
- R6: MISO is captured MSB first as SCK returns from active to idle. Each completed group of 8 captured bits appears on `rx_data` with a one-cycle `rx_valid` pulse.
- R7: When the bit count n is not a multiple of 8, a final byte is emitted holding the last n mod 8 captured bits in its top positions and zeros below. The total number of bytes emitted is ceil(n/8).
- R8: `done` is high for exactly one cycle per transfer, after the last `rx_valid` of that transfer, and `busy` is low in the next cycle.
- R9: `busy` stays high for ceil(n/8) + 2·n·(`half_div`+1) + 2 cycles when `tx_valid` is held high.
- R10: A bit count of zero gives a two-cycle busy period with no SCK edge, no `tx_ready` and no received byte, and it still applies the chip-select flags.
- R11: A `start` pulse while `busy` is high is ignored. The running transfer is unchanged and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (taken only when idle) |
| len_bits | input | LEN_W | Number of bits to shift |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase: 1 delays the active half by one half-period |
| cs_begin | input | 1 | Assert chip select at the start of this transfer |
| cs_end | input | 1 | Release chip select at the end of this transfer |
| half_div | input | DIV_W | SCK half-period minus one, in clocks |
| tx_data | input | 8 | Next byte to send |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_ready | output | 1 | Byte taken in this cycle if `tx_valid` |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle pulse marking `rx_data` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
Two things can fall into the same stretch of cycles. One is the completion of a full received byte. The other is the flush that closes the transfer, which either emits the partial last byte or emits nothing. When the bit count is a multiple of eight, the last capture completes a byte immediately before the flush, and the flush must then add no second byte. The bench sweeps every bit count from 0 to 20 under all four clock modes, so lengths on and next to byte boundaries (7, 8, 9, 15, 16, 17) are covered in both phases. It judges each case by the number and value of received bytes, arithmetically predicted, and by `done` arriving only after the last of them.

// File: rtl/spi_sm_pkg.sv
package spi_sm_pkg;

   localparam int BYTE_BITS = 8;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LOAD   = 3'd1,
      ST_HALF_A = 3'd2,
      ST_HALF_B = 3'd3,
      ST_FLUSH  = 3'd4,
      ST_FIN    = 3'd5
   } xfer_state_t;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] limit,
   output logic             tick
);

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("spi_half_timer: DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         step,
   output logic         bit_out
);

   generate
      if (W < 2) begin : g_bad_w
         $error("spi_tx_shift: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         bit_out <= 1'b0;
      end else if (load) begin
         bit_out <= load_data[W-1];
         sh_q    <= {load_data[W-2:0], 1'b0};
      end else if (step) begin
         bit_out <= sh_q[W-1];
         sh_q    <= {sh_q[W-2:0], 1'b0};
      end
   end

   // R4: a freshly loaded byte puts its top bit on the line first
   p_load_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (bit_out == $past(load_data[W-1])));

endmodule

// File: rtl/spi_rx_pack.sv
module spi_rx_pack #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         sample,
   input  logic         bit_in,
   input  logic         flush,
   output logic [W-1:0] out_data,
   output logic         out_valid
);

   localparam int CW = $clog2(W);

   generate
      if (W < 2 || (1 << CW) != W) begin : g_bad_w
         $error("spi_rx_pack: W must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  acc_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         cnt_q     <= '0;
         out_data  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (clear) begin
            acc_q <= '0;
            cnt_q <= '0;
         end else if (sample) begin
            acc_q <= {acc_q[W-2:0], bit_in};
            if (cnt_q == CW'(W-1)) begin
               out_data  <= {acc_q[W-2:0], bit_in};
               out_valid <= 1'b1;
               cnt_q     <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (flush) begin
            if (cnt_q != '0) begin
               out_data  <= acc_q << (W - int'(cnt_q));
               out_valid <= 1'b1;
            end
            cnt_q <= '0;
         end
      end
   end

   // R6: captures are at least two clocks apart, so bytes never come back to back
   p_rx_spaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
   import spi_sm_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len_bits,
   input  logic             cpol,
   input  logic             cpha,
   input  logic             cs_begin,
   input  logic             cs_end,
   input  logic [DIV_W-1:0] half_div,
   input  logic [7:0]       tx_data,
   input  logic             tx_valid,
   output logic             tx_ready,
   output logic [7:0]       rx_data,
   output logic             rx_valid,
   output logic             busy,
   output logic             done,
   output logic             sck,
   output logic             mosi,
   input  logic             miso,
   output logic             cs_n
);

   localparam int BC_W = $clog2(BYTE_BITS);

   generate
      if (LEN_W < 1) begin : g_bad_len
         $error("spi_shift_master: LEN_W must be at least 1");
      end
      if (BYTE_BITS != 8) begin : g_bad_byte
         $error("spi_shift_master: byte streams are 8 bits wide");
      end
   endgenerate

   xfer_state_t      state_q;
   logic             cpol_q;
   logic             cpha_q;
   logic             endf_q;
   logic [DIV_W-1:0] div_q;
   logic [LEN_W-1:0] left_q;
   logic [BC_W-1:0]  txbit_q;
   logic             sck_q;
   logic             cs_q;
   logic             armed_q;

   logic tick;
   logic half_run;
   logic tx_load;
   logic step_bit;
   logic sample;
   logic last_bit;
   logic byte_end;

   assign half_run = (state_q == ST_HALF_A) || (state_q == ST_HALF_B);
   assign tx_ready = (state_q == ST_LOAD);
   assign tx_load  = tx_ready && tx_valid;
   assign last_bit = (left_q == LEN_W'(1));
   assign byte_end = (txbit_q == BC_W'(BYTE_BITS-1));
   assign step_bit = (state_q == ST_HALF_B) && tick && !last_bit && !byte_end;
   assign sample   = tick && (((state_q == ST_HALF_A) && !cpha_q) ||
                              ((state_q == ST_HALF_B) &&  cpha_q));

   assign busy = (state_q != ST_IDLE);
   assign done = (state_q == ST_FIN);
   assign sck  = sck_q;
   assign cs_n = cs_q;

   spi_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (half_run),
      .limit (div_q),
      .tick  (tick)
   );

   spi_tx_shift #(.W(BYTE_BITS)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tx_load),
      .load_data (tx_data),
      .step      (step_bit),
      .bit_out   (mosi)
   );

   spi_rx_pack #(.W(BYTE_BITS)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     ((state_q == ST_IDLE) && start),
      .sample    (sample),
      .bit_in    (miso),
      .flush     (state_q == ST_FLUSH),
      .out_data  (rx_data),
      .out_valid (rx_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cpol_q  <= 1'b0;
         cpha_q  <= 1'b0;
         endf_q  <= 1'b0;
         div_q   <= '0;
         left_q  <= '0;
         txbit_q <= '0;
         sck_q   <= 1'b0;
         cs_q    <= 1'b1;
         armed_q <= 1'b0;
      end else begin
         armed_q <= 1'b1;
         unique case (state_q)
            ST_IDLE: begin
               sck_q <= cpol;
               if (start) begin
                  cpol_q <= cpol;
                  cpha_q <= cpha;
                  endf_q <= cs_end;
                  div_q  <= half_div;
                  left_q <= len_bits;
                  if (cs_begin) begin
                     cs_q <= 1'b0;
                  end
                  state_q <= (len_bits == '0) ? ST_FLUSH : ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (tx_valid) begin
                  txbit_q <= '0;
                  if (!cpha_q) begin
                     sck_q <= ~cpol_q;
                  end
                  state_q <= ST_HALF_A;
               end
            end
            ST_HALF_A: begin
               if (tick) begin
                  sck_q   <= cpha_q ? ~cpol_q : cpol_q;
                  state_q <= ST_HALF_B;
               end
            end
            ST_HALF_B: begin
               if (tick) begin
                  sck_q  <= cpol_q;
                  left_q <= left_q - 1'b1;
                  if (last_bit) begin
                     state_q <= ST_FLUSH;
                  end else if (byte_end) begin
                     state_q <= ST_LOAD;
                  end else begin
                     txbit_q <= txbit_q + 1'b1;
                     if (!cpha_q) begin
                        sck_q <= ~cpol_q;
                     end
                     state_q <= ST_HALF_A;
                  end
               end
            end
            ST_FLUSH: begin
               state_q <= ST_FIN;
            end
            ST_FIN: begin
               if (endf_q) begin
                  cs_q <= 1'b1;
               end
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   // R1: idle clock is parked at the requested polarity
   p_idle_park_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !busy && $past(!busy)) |-> (sck == $past(cpol)));

   // R2: select only drops on an accepted start carrying the begin flag
   p_cs_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> $past(start && cs_begin && !busy));

   // R3: select only rises right after the end-of-transfer pulse
   p_cs_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> $past(done));

   // R8: the end pulse is followed by idle
   p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R10: an empty transfer ends two cycles after it is accepted
   p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (len_bits == '0)) |=> ##1 done);

endmodule

// File: tb/spi_shift_master_test.sv
module spi_shift_master_test;

   localparam int LW = 16;
   localparam int DW = 8;

   logic          clk;
   logic          rst_n;
   logic          start;
   logic [LW-1:0] len_bits;
   logic          cpol;
   logic          cpha;
   logic          cs_begin;
   logic          cs_end;
   logic [DW-1:0] half_div;
   logic [7:0]    tx_data;
   logic          tx_valid;
   logic          tx_ready;
   logic [7:0]    rx_data;
   logic          rx_valid;
   logic          busy;
   logic          done;
   logic          sck;
   logic          mosi;
   logic          miso;
   logic          cs_n;

   spi_shift_master #(.LEN_W(LW), .DIV_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .len_bits(len_bits),
      .cpol(cpol), .cpha(cpha), .cs_begin(cs_begin), .cs_end(cs_end),
      .half_div(half_div), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
      .busy(busy), .done(done), .sck(sck), .mosi(mosi), .miso(miso),
      .cs_n(cs_n)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   int total = 0;
   int bad   = 0;

   // context of the running transfer
   int cur_len, cur_div, cur_seed;
   bit cur_cpol, cur_cpha, cur_beg, cur_end;
   // monitor results
   int bitk, txi, rxi, busy_cyc, first_act, act_len;
   int width_bad, mosi_bad, rx_bad, cs_bad, ready_cnt;
   int busy_rises, done_cnt, done_order_bad;
   bit cs_exp, prev_sck, prev_busy, tx_pend;
   logic [7:0] tmp_byte;
   logic [7:0] exp_byte;

   function automatic logic [7:0] txpat(input int seed, input int i);
      return 8'((i * 29) + (seed * 7) + 8'h3C);
   endfunction

   function automatic logic [7:0] rxpat(input int seed, input int i);
      return 8'((i * 53) ^ (seed * 11) ^ 8'hC5);
   endfunction

   function automatic int nbytes(input int n);
      return (n + 7) / 8;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // bus-side model: slave, stream source and observers, all at the falling edge
   initial begin
      cs_exp = 1'b1;
      prev_sck = 1'b0;
      prev_busy = 1'b0;
      tx_pend = 1'b0;
      miso = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (tx_pend) begin
               txi++;
               tx_data = txpat(cur_seed, txi);
               tx_pend = 1'b0;
            end
            if (tx_ready) begin
               ready_cnt++;
               tx_pend = 1'b1;
            end
            if (busy) busy_cyc++;
            if (busy && !prev_busy) begin
               busy_rises++;
               if (cur_beg) cs_exp = 1'b0;
            end
            if (!busy && prev_busy && cur_end) cs_exp = 1'b1;
            if (cs_n !== cs_exp) cs_bad++;
            if (busy && sck !== cur_cpol && prev_sck === cur_cpol) begin
               if (bitk == 0) first_act = busy_cyc;
               tmp_byte = txpat(cur_seed, bitk / 8);
               if (mosi !== tmp_byte[7 - (bitk % 8)]) mosi_bad++;
               tmp_byte = rxpat(cur_seed, bitk / 8);
               miso = tmp_byte[7 - (bitk % 8)];
               bitk++;
            end
            if (busy && sck !== cur_cpol) begin
               act_len++;
            end else if (act_len != 0) begin
               if (act_len != cur_div + 1) width_bad++;
               act_len = 0;
            end
            if (rx_valid) begin
               exp_byte = rxpat(cur_seed, rxi);
               if ((rxi + 1) * 8 > cur_len)
                  exp_byte = exp_byte & (8'hFF << (8 - (cur_len % 8)));
               if (rx_data !== exp_byte) rx_bad++;
               rxi++;
            end
            if (done) begin
               done_cnt++;
               if (rxi != nbytes(cur_len)) done_order_bad++;
            end
            prev_sck = sck;
            prev_busy = busy;
         end
      end
   end

   task automatic run_xfer(input int len, input bit pol, input bit pha, input int dv,
                           input bit beg, input bit en, input int seed, input bit poke);
      int nb;
      @(negedge clk);
      cur_len = len; cur_div = dv; cur_seed = seed;
      cur_cpol = pol; cur_cpha = pha; cur_beg = beg; cur_end = en;
      bitk = 0; txi = 0; rxi = 0; busy_cyc = 0; first_act = 0; act_len = 0;
      width_bad = 0; mosi_bad = 0; rx_bad = 0; cs_bad = 0; ready_cnt = 0;
      busy_rises = 0; done_cnt = 0; done_order_bad = 0; tx_pend = 1'b0;
      cpol = pol; cpha = pha; half_div = DW'(dv); len_bits = LW'(len);
      cs_begin = beg; cs_end = en;
      tx_data = txpat(seed, 0); tx_valid = 1'b1;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (6) @(negedge clk);
         start = 1'b1; len_bits = LW'(3); cs_begin = 1'b1; cs_end = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      repeat (3) @(negedge clk);
      nb = nbytes(len);
      chk(mosi_bad == 0 && bitk == len, "R4 mosi bits", mosi_bad * 1000 + bitk, len);
      chk(ready_cnt == nb, "R4 tx_ready count", ready_cnt, nb);
      if (len % 8 != 0)
         chk(rx_bad == 0 && rxi == nb, "R7 partial byte", rx_bad * 1000 + rxi, nb);
      else
         chk(rx_bad == 0 && rxi == nb, "R6 rx bytes", rx_bad * 1000 + rxi, nb);
      chk(done_cnt == 1 && done_order_bad == 0, "R8 done order", done_cnt + 10 * done_order_bad, 1);
      chk(busy_cyc == nb + 2 * len * (dv + 1) + 2, "R9 busy length", busy_cyc,
          nb + 2 * len * (dv + 1) + 2);
      if (len > 0) begin
         chk(first_act == 2 + (pha ? dv + 1 : 0), "R5 phase delay", first_act,
             2 + (pha ? dv + 1 : 0));
         chk(width_bad == 0, "R5 active width", width_bad, 0);
      end else begin
         chk(bitk == 0 && ready_cnt == 0 && rxi == 0 && busy_cyc == 2, "R10 empty transfer",
             bitk + ready_cnt + rxi + busy_cyc, 2);
      end
      chk(cs_bad == 0, beg ? "R2 cs assert" : "R3 cs release", cs_bad, 0);
      chk(sck == pol, "R1 sck parked after transfer", sck, pol);
      if (poke) chk(busy_rises == 1 && !busy, "R11 start while busy", busy_rises, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; len_bits = '0; cpol = 1'b0; cpha = 1'b0;
      cs_begin = 1'b0; cs_end = 1'b0; half_div = '0; tx_data = '0; tx_valid = 1'b0;
      cur_len = 0; cur_div = 0; cur_seed = 0; cur_cpol = 1'b0; cur_cpha = 1'b0;
      cur_beg = 1'b0; cur_end = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !tx_ready && !rx_valid, "R8 reset outputs",
          busy + done + tx_ready + rx_valid, 0);
      chk(cs_n == 1'b1, "R2 reset cs_n", cs_n, 1);
      chk(sck == 1'b0, "R1 reset idle sck", sck, 0);
      // R1: idle clock follows polarity changes
      cpol = 1'b1;
      repeat (2) @(negedge clk);
      chk(sck == 1'b1, "R1 idle follows cpol=1", sck, 1);
      cpol = 1'b0;
      repeat (2) @(negedge clk);
      chk(sck == 1'b0, "R1 idle follows cpol=0", sck, 0);
      // full sweep over lengths and modes
      for (int len = 0; len <= 20; len++) begin
         for (int m = 0; m < 4; m++) begin
            run_xfer(len, m[1], m[0], (len + m) % 3, ((len + m) % 2) == 0,
                     ((len + 3 * m) % 3) != 1, len * 4 + m, (len == 12 && m == 2));
         end
      end
      // R3: select held across two transfers, released only at the second end
      run_xfer(5, 1'b0, 1'b1, 1, 1'b1, 1'b0, 200, 1'b0);
      chk(cs_n == 1'b0, "R3 cs held between transfers", cs_n, 0);
      run_xfer(11, 1'b0, 1'b1, 1, 1'b0, 1'b1, 201, 1'b0);
      chk(cs_n == 1'b1, "R3 cs released after second", cs_n, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule